// File: doc/BRIEF.md
# Fractional Crystal Prescaler

This block sits between a crystal oscillator and a time-of-day counter chain. It receives a one-cycle enable for every crystal period, runs in the system clock domain, and produces three single-cycle tick streams: an intermediate 4000 Hz tick, the 100 Hz tick that advances the hundredths counter, and a 10 Hz tick that marks each tenth of a second.

All supported crystal rates are powers of two, so 4000 Hz cannot be reached by an integer divider. The first stage is a phase accumulator. It adds 4000 for every crystal cycle and subtracts the crystal rate each time the sum reaches it. This gives exactly 4000 intermediate ticks per second, and the spacing between ticks varies by at most one crystal cycle. A modulo-40 counter then turns the 4000 Hz tick into 100 Hz. The 10 Hz tick is counted from the 100 Hz ticks that actually reach the counters. A run bit gates those ticks off. A test bit sends every crystal cycle straight onto the 100 Hz output, which speeds up the counter chain.

Top module: `xtal_prescaler`

## Requirements
- R1: `freq_sel_i` selects the crystal modulus: 0 = 32768, 1 = 1048576, 2 = 2097152, 3 = 4194304 crystal cycles per second.
- R2: On each cycle with `xtal_en_i` high and the select unchanged, the accumulator adds 4000. When the sum reaches the modulus, the modulus is subtracted and `tick_4k_o` pulses for one cycle in the following clock cycle. Starting from a cleared state, exactly 4000 pulses occur for every modulus count of enables.
- R3: With `test_i` low and `run_i` high, `tick_100_o` pulses together with every 40th `tick_4k_o` pulse.
- R4: While `run_i` is low, `tick_100_o` and `tick_10_o` stay low, and the 4000 Hz stage and the divide-by-40 stage keep counting.
- R5: With `test_i` high and `run_i` high, `tick_100_o` pulses in the cycle after every cycle in which `xtal_en_i` is high.
- R6: `tick_10_o` pulses together with every tenth delivered `tick_100_o` pulse, counted from reset.
- R7: In a cycle where `freq_sel_i` differs from its value in the previous cycle, the accumulator and the divide-by-40 stage clear, and that cycle's enable produces no `tick_4k_o`.
- R8: While `rst_ni` is low, all outputs are low and all stages are cleared.

Top module port order follows the table below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xtal_en_i | input | 1 | One pulse per crystal cycle |
| freq_sel_i | input | 2 | Crystal rate select (R1 encoding) |
| run_i | input | 1 | 1 = deliver 100 Hz ticks, 0 = hold counters |
| test_i | input | 1 | 1 = crystal cycles drive the 100 Hz output |
| tick_4k_o | output | 1 | 4000 Hz intermediate tick |
| tick_100_o | output | 1 | 100 Hz counting tick |
| tick_10_o | output | 1 | 10 Hz tick |

## Verification
The bench runs one full second at the 32 kHz rate and checks for exactly 4000, 100 and 10 ticks. A rounded integer divider, or an accumulator that loses the remainder at the wrap, would miss these totals. The bench then changes the select with an enable present in the same cycle. A design that failed to clear, or that counted that enable, would produce its first 4 kHz tick at a different cycle than the reference model. It also runs with the run bit low, where any leaked 100 Hz tick shows up, and with test mode on and a sparse enable, where a design that still used the divided tick would produce far too few pulses.

// File: rtl/xpre_pkg.sv
package xpre_pkg;
  localparam int unsigned XPRE_STEP      = 4000;
  localparam int unsigned XPRE_BASE_LOG2 = 15;

  // crystal cycles per second for each select code
  function automatic logic [31:0] xpre_modulus(input logic [1:0] sel);
    logic [31:0] m;
    case (sel)
      2'd0:    m = 32'd1 << XPRE_BASE_LOG2;
      2'd1:    m = 32'd1 << (XPRE_BASE_LOG2 + 5);
      2'd2:    m = 32'd1 << (XPRE_BASE_LOG2 + 6);
      default: m = 32'd1 << (XPRE_BASE_LOG2 + 7);
    endcase
    return m;
  endfunction
endpackage

// File: rtl/xpre_phase_acc.sv
module xpre_phase_acc #(
  parameter int unsigned ACC_W = 23,
  parameter int unsigned STEP  = 4000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [ACC_W-1:0] modulus_i,
  output logic             wrap_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;

  assign sum    = acc_q + ACC_W'(STEP);
  assign wrap_o = en_i && !clr_i && (sum >= modulus_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clr_i)   acc_q <= '0;
    else if (en_i)    acc_q <= wrap_o ? (sum - modulus_i) : sum;
  end
endmodule

// File: rtl/xpre_mod_counter.sv
module xpre_mod_counter #(
  parameter int unsigned MOD = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);
  localparam int unsigned CW = (MOD > 1) ? $clog2(MOD) : 1;
  logic [CW-1:0] cnt_q;

  assign last_o = en_i && !clr_i && (cnt_q == CW'(MOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/xtal_prescaler.sv
module xtal_prescaler #(
  parameter int unsigned ACC_W   = 23,
  parameter int unsigned MID_DIV = 40,
  parameter int unsigned LOW_DIV = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       xtal_en_i,
  input  logic [1:0] freq_sel_i,
  input  logic       run_i,
  input  logic       test_i,
  output logic       tick_4k_o,
  output logic       tick_100_o,
  output logic       tick_10_o
);
  import xpre_pkg::*;

  logic [1:0]       sel_q;
  logic             sel_chg;
  logic [ACC_W-1:0] modulus;
  logic             wrap_4k;
  logic             last_mid;
  logic             deliver;
  logic             last_low;

  assign sel_chg = (freq_sel_i != sel_q);
  assign modulus = ACC_W'(xpre_modulus(freq_sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= freq_sel_i;
  end

  xpre_phase_acc #(.ACC_W(ACC_W), .STEP(XPRE_STEP)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (sel_chg),
    .en_i      (xtal_en_i),
    .modulus_i (modulus),
    .wrap_o    (wrap_4k)
  );

  xpre_mod_counter #(.MOD(MID_DIV)) u_mid (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sel_chg),
    .en_i   (wrap_4k),
    .last_o (last_mid)
  );

  // test mode bypasses both dividers
  assign deliver = run_i && (test_i ? xtal_en_i : last_mid);

  xpre_mod_counter #(.MOD(LOW_DIV)) u_low (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (1'b0),
    .en_i   (deliver),
    .last_o (last_low)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_4k_o  <= 1'b0;
      tick_100_o <= 1'b0;
      tick_10_o  <= 1'b0;
    end else begin
      tick_4k_o  <= wrap_4k;
      tick_100_o <= deliver;
      tick_10_o  <= last_low;
    end
  end
endmodule

// File: rtl/xpre_chk.sv
module xpre_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       xtal_en_i,
  input logic [1:0] freq_sel_i,
  input logic       run_i,
  input logic       test_i,
  input logic       tick_4k_o,
  input logic       tick_100_o,
  input logic       tick_10_o
);
  // R2
  tick_4k_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_4k_o |-> $past(xtal_en_i));

  // R3
  div_tick_on_4k_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_100_o && !$past(test_i)) |-> tick_4k_o);

  // R4
  stop_blocks_ticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!tick_100_o && !tick_10_o));

  // R5
  test_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_i && run_i && xtal_en_i) |=> tick_100_o);

  // R6
  tenth_with_hundredth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_10_o |-> tick_100_o);

  // R7
  sel_change_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_sel_i != $past(freq_sel_i)) |=> !tick_4k_o);
endmodule

bind xtal_prescaler xpre_chk u_xpre_chk (.*);

// File: tb/tb_xtal_prescaler.sv
module tb_xtal_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xtal_en = 1'b0;
  logic [1:0] freq_sel = 2'd0;
  logic       run = 1'b0;
  logic       test = 1'b0;
  logic       t4k, t100, t10;

  int checks = 0, fails = 0, cyc = 0;
  int n4k = 0, n100 = 0, n10 = 0;
  // reference model state
  int  m_acc = 0, m_c40 = 0, m_c10 = 0;
  logic [1:0] m_sel = 2'd0;
  bit  x4 = 0, x100 = 0, x10 = 0;

  always #10 clk = ~clk;

  xtal_prescaler dut (
    .clk_i(clk), .rst_ni(rst_n), .xtal_en_i(xtal_en), .freq_sel_i(freq_sel),
    .run_i(run), .test_i(test),
    .tick_4k_o(t4k), .tick_100_o(t100), .tick_10_o(t10)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int  modv;
    bit  mid, deliver;
    if (!rst_n) begin
      m_acc = 0; m_c40 = 0; m_c10 = 0; m_sel = 2'd0;
      x4 = 0; x100 = 0; x10 = 0;
    end else begin
      modv = 32768 << ((freq_sel == 2'd0) ? 0 : int'(freq_sel) + 4);
      x4 = 0; x10 = 0; mid = 0;
      if (freq_sel != m_sel) begin
        m_sel = freq_sel; m_acc = 0; m_c40 = 0;
      end else if (xtal_en) begin
        m_acc += 4000;
        if (m_acc >= modv) begin
          m_acc -= modv; x4 = 1; m_c40++;
          if (m_c40 == 40) begin m_c40 = 0; mid = 1; end
        end
      end
      deliver = run && (test ? xtal_en : mid);
      if (deliver) begin
        m_c10++;
        if (m_c10 == 10) begin m_c10 = 0; x10 = 1; end
      end
      x100 = deliver;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 tick_4k", int'(t4k), int'(x4));
      chk("R3 tick_100", int'(t100), int'(x100));
      chk("R6 tick_10", int'(t10), int'(x10));
      n4k += int'(t4k); n100 += int'(t100); n10 += int'(t10);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      fails++; checks++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step(input bit en, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      xtal_en = en;
    end
  endtask

  task automatic flush();
    step(0, 3);
  endtask

  initial begin
    int a4, a100, a10;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset tick_4k", int'(t4k), 0);
    chk("R8 reset tick_100", int'(t100), 0);
    chk("R8 reset tick_10", int'(t10), 0);
    rst_n = 1'b1;
    run = 1'b1;
    step(0, 2);

    // R1/R2/R3/R6: one full second at 32 kHz
    a4 = n4k; a100 = n100; a10 = n10;
    step(1, 32768); flush();
    chk("R2 R1 4k per second", n4k - a4, 4000);
    chk("R3 100 per second", n100 - a100, 100);
    chk("R6 10 per second", n10 - a10, 10);

    // R4 stopped: 4 kHz continues, counting ticks suppressed
    run = 1'b0;
    a4 = n4k; a100 = n100; a10 = n10;
    step(1, 5000); flush();
    chk("R4 4k continues", n4k - a4, 610);
    chk("R4 no 100", n100 - a100, 0);
    chk("R4 no 10", n10 - a10, 0);
    run = 1'b1;

    // R5 test mode with a sparse enable
    test = 1'b1;
    a100 = n100; a10 = n10;
    for (int i = 0; i < 100; i++) begin step(1, 1); step(0, 1); end
    flush();
    chk("R5 test 100", n100 - a100, 100);
    chk("R6 test 10", n10 - a10, 10);
    test = 1'b0;

    // R7 select change with enable in the change cycle
    @(negedge clk); freq_sel = 2'd1; xtal_en = 1'b1;
    a4 = n4k;
    step(1, 30000); flush();
    chk("R7 R1 1M window", n4k - a4, 114);

    @(negedge clk); freq_sel = 2'd3; xtal_en = 1'b1;
    a4 = n4k;
    step(1, 10000); flush();
    chk("R7 R1 4M window", n4k - a4, 9);

    @(negedge clk); freq_sel = 2'd2; xtal_en = 1'b1;
    a4 = n4k;
    step(1, 10000); flush();
    chk("R7 R1 2M window", n4k - a4, 19);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule